// File: doc/BRIEF.md
# Cascadable Wideband Output Summer

This block builds the wideband sample stream that feeds a DAC. On every master clock it adds the samples of several local channels to a wideband word from an upstream device. It saturates the total to the signed width of the shared bus and registers it onto the output bus. Devices are chained by wiring one block's output bus and qualifier into the next block's cascade input, so the last block in the chain carries the sum of every channel on the chain. The whole chain runs on a single master clock, which is the DAC sample clock.

In real mode, every output word is the sum of the in-phase (I) samples. In quadrature mode, I and Q take turns on the same bus, and a qualifier bit travels with each word to mark which lane it carries.

The lane is chosen in one of two ways:
- **Chain head:** the block generates its own alternating qualifier, starting with I.
- **Downstream block:** the block follows the qualifier that arrives with the cascade word.

An output enable forces the bus and the qualifier to zero without disturbing the registered sum.

Top module: `wb_summer`

## Requirements
- R1: In real mode the output bus shows, one clock after the inputs are sampled, the signed sum of the cascade word and every channel's I sample (channel k occupies bits [18k+17:18k] of the packed channel vectors).
- R2: A sum above 131071 is clamped to 131071; a sum of exactly 131071 passes unchanged.
- R3: A sum below -131072 is clamped to -131072.
- R4: In real mode the output qualifier is 0.
- R5: In quadrature mode with `chainIn` = 0, the lane alternates on every clock. The first quadrature clock after reset uses I, and the output qualifier is 0 for a word built from I samples and 1 for a word built from Q samples.
- R6: In quadrature mode with `chainIn` = 1, the lane is taken from `cascQual` (0 selects I, 1 selects Q) in the cycle it is sampled, and the output qualifier is that `cascQual` value delayed by one clock.
- R7: While `outEn` is 0, `wbOut` and `wbQual` are 0 in the same cycle. The registered sum keeps updating and reappears as soon as `outEn` returns to 1.
- R8: After reset the output bus and the qualifier are 0.
- R9: Leaving quadrature mode clears the lane phase, so the next entry into quadrature mode begins with I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (DAC sample clock) |
| rstN | input | 1 | Asynchronous active-low reset |
| quadMode | input | 1 | 1 = quadrature interleaved output, 0 = real output |
| chainIn | input | 1 | 1 = lane follows `cascQual`; 0 = local alternating lane |
| outEn | input | 1 | Output enable; 0 forces outputs to zero |
| cascIn | input | 18 | Signed wideband word from the upstream device |
| cascQual | input | 1 | Lane qualifier arriving with `cascIn` |
| chanI | input | 72 | Packed signed I samples of the local channels |
| chanQ | input | 72 | Packed signed Q samples of the local channels |
| wbOut | output | 18 | Signed saturated wideband output word |
| wbQual | output | 1 | Lane qualifier of `wbOut` (0 = I, 1 = Q) |

## Verification
The bench targets both clamp directions and the exact positive limit. A design that wraps instead of clamping shows a small value of the wrong sign, and an off-by-one clamp alters a legal full-scale word. It checks that the first quadrature word after reset, and after a return from real mode, is built from I samples. A design that keeps a stale phase or starts on Q would interleave the lanes backwards. A chained pattern that repeats the same `cascQual` value twice exposes a block that toggles by itself instead of following upstream. Disabling the output mid-stream exposes a design that freezes or clears the sum instead of only masking the bus.

// File: rtl/wb_summer_pkg.sv
package wb_summer_pkg;
  // Strobes from the lane control to the summing datapath
  typedef struct packed {
    logic selQ;      // add Q samples instead of I samples this cycle
    logic qualNext;  // qualifier to register alongside the sum
  } laneStrobe_t;
endpackage

// File: rtl/wb_summer_ctrl.sv
module wb_summer_ctrl
  import wb_summer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        quadMode,
  input  logic        chainIn,
  input  logic        cascQual,
  output laneStrobe_t strobe,
  output logic        phase
);
  logic lane;

  // Local lane phase: 0 = I, toggles each quadrature clock, cleared in real mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          phase <= 1'b0;
    else if (!quadMode) phase <= 1'b0;
    else                phase <= ~phase;
  end

  always_comb begin
    lane            = chainIn ? cascQual : phase;
    strobe.selQ     = quadMode & lane;
    strobe.qualNext = quadMode & lane;
  end
endmodule

// File: rtl/wb_summer_dp.sv
module wb_summer_dp
  import wb_summer_pkg::*;
#(
  parameter int W   = 18,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              outEn,
  input  laneStrobe_t       strobe,
  input  logic [W-1:0]      cascIn,
  input  logic [NCH*W-1:0]  chanI,
  input  logic [NCH*W-1:0]  chanQ,
  output logic [W-1:0]      wbOut,
  output logic              wbQual,
  output logic              qualR
);
  localparam int SW = W + $clog2(NCH + 1);
  localparam logic signed [SW-1:0] MAXV = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [W-1:0]  picked [NCH];
  logic signed [SW-1:0] acc;
  logic [W-1:0]         satSum;
  logic [W-1:0]         sumR;

  // Per-channel lane selection
  for (genvar g = 0; g < NCH; g++) begin : g_pick
    assign picked[g] = strobe.selQ ? $signed(chanQ[g*W +: W]) : $signed(chanI[g*W +: W]);
  end

  // Wide accumulation, then clamp to the bus range
  always_comb begin
    acc = SW'($signed(cascIn));
    for (int i = 0; i < NCH; i++) acc = acc + SW'(picked[i]);
    if (acc > MAXV)      satSum = MAXV[W-1:0];
    else if (acc < MINV) satSum = MINV[W-1:0];
    else                 satSum = acc[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumR  <= '0;
      qualR <= 1'b0;
    end else begin
      sumR  <= satSum;
      qualR <= strobe.qualNext;
    end
  end

  // Disabled bus is modelled as zero
  assign wbOut  = outEn ? sumR  : '0;
  assign wbQual = outEn ? qualR : 1'b0;
endmodule

// File: rtl/wb_summer.sv
module wb_summer
  import wb_summer_pkg::*;
#(
  parameter int W   = 18,
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             quadMode,
  input  logic             chainIn,
  input  logic             outEn,
  input  logic [W-1:0]     cascIn,
  input  logic             cascQual,
  input  logic [NCH*W-1:0] chanI,
  input  logic [NCH*W-1:0] chanQ,
  output logic [W-1:0]     wbOut,
  output logic             wbQual
);
  laneStrobe_t strobe;
  logic        phase;
  logic        qualR;

  wb_summer_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .quadMode(quadMode), .chainIn(chainIn),
    .cascQual(cascQual), .strobe(strobe), .phase(phase)
  );

  wb_summer_dp #(.W(W), .NCH(NCH)) i_dp (
    .clk(clk), .rstN(rstN), .outEn(outEn), .strobe(strobe),
    .cascIn(cascIn), .chanI(chanI), .chanQ(chanQ),
    .wbOut(wbOut), .wbQual(wbQual), .qualR(qualR)
  );
endmodule

// File: rtl/wb_summer_chk.sv
module wb_summer_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rstN,
  input logic         quadMode,
  input logic         chainIn,
  input logic         outEn,
  input logic         cascQual,
  input logic [W-1:0] wbOut,
  input logic         wbQual,
  input logic         phase,
  input logic         qualR
);
  a_r4_real_qual_low: assert property (@(posedge clk) disable iff (!rstN)
    !quadMode |=> !qualR);

  a_r5_phase_toggle: assert property (@(posedge clk) disable iff (!rstN)
    quadMode |=> (phase != $past(phase)));

  a_r5_head_qual: assert property (@(posedge clk) disable iff (!rstN)
    (quadMode && !chainIn) |=> (qualR == $past(phase)));

  a_r6_chain_qual: assert property (@(posedge clk) disable iff (!rstN)
    (quadMode && chainIn) |=> (qualR == $past(cascQual)));

  a_r7_disabled_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (wbOut == '0 && !wbQual));

  a_r9_phase_clear: assert property (@(posedge clk) disable iff (!rstN)
    !quadMode |=> !phase);
endmodule

bind wb_summer wb_summer_chk #(.W(W)) i_chk (
  .clk(clk), .rstN(rstN), .quadMode(quadMode), .chainIn(chainIn),
  .outEn(outEn), .cascQual(cascQual), .wbOut(wbOut), .wbQual(wbQual),
  .phase(phase), .qualR(qualR)
);

// File: tb/test_wb_summer.sv
module test_wb_summer;
  localparam int W   = 18;
  localparam int NCH = 4;
  localparam int MAXV = 131071;
  localparam int MINV = -131072;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             quadMode = 1'b0, chainIn = 1'b0, outEn = 1'b1, cascQual = 1'b0;
  logic [W-1:0]     cascIn = '0;
  logic [NCH*W-1:0] chanI = '0, chanQ = '0;
  logic [W-1:0]     wbOut;
  logic             wbQual;

  int nChecks = 0;
  int nFails  = 0;
  int vI [NCH];
  int vQ [NCH];
  int vC;

  always #10 clk = ~clk;

  wb_summer #(.W(W), .NCH(NCH)) i_wb_summer (
    .clk(clk), .rstN(rstN), .quadMode(quadMode), .chainIn(chainIn),
    .outEn(outEn), .cascIn(cascIn), .cascQual(cascQual),
    .chanI(chanI), .chanQ(chanQ), .wbOut(wbOut), .wbQual(wbQual)
  );

  function automatic int clampSum(input int c, input logic useQ);
    int s = c;
    for (int k = 0; k < NCH; k++) s += useQ ? vQ[k] : vI[k];
    if (s > MAXV) s = MAXV;
    if (s < MINV) s = MINV;
    return s;
  endfunction

  task automatic load(input int c, input int bI, input int bQ);
    vC = c;
    for (int k = 0; k < NCH; k++) begin
      vI[k] = bI * (k + 1);
      vQ[k] = bQ * (k + 1) - 7;
      chanI[k*W +: W] = W'(vI[k]);
      chanQ[k*W +: W] = W'(vQ[k]);
    end
    cascIn = W'(c);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int expOut, input logic expQual);
    nChecks++;
    if ($signed(wbOut) !== expOut || wbQual !== expQual) begin
      nFails++;
      $display("FAIL %s: out=%0d qual=%0b expected out=%0d qual=%0b",
               req, $signed(wbOut), wbQual, expOut, expQual);
    end
  endtask

  task automatic t_reset();
    check("R8", 0, 1'b0);
  endtask

  task automatic t_real();
    int e;
    quadMode = 0; chainIn = 0;
    load(100, 10, -20);
    e = clampSum(vC, 1'b0);
    step(); check("R1", e, 1'b0);
    load(-5000, -300, 77);
    e = clampSum(vC, 1'b0);
    step(); check("R1", e, 1'b0);
    cascQual = 1;
    load(0, 1234, 5);
    e = clampSum(vC, 1'b0);
    step(); check("R4", e, 1'b0);
    cascQual = 0;
  endtask

  task automatic t_sat();
    quadMode = 0;
    load(MAXV, 1000, 0);
    step(); check("R2", MAXV, 1'b0);
    load(MAXV - 10, 1, 0);   // I sum = 1+2+3+4 = 10, exact limit
    step(); check("R2", MAXV, 1'b0);
    load(MAXV - 11, 1, 0);
    step(); check("R2", MAXV - 1, 1'b0);
    load(MINV, -5, 0);
    step(); check("R3", MINV, 1'b0);
    load(100000, 20000, 0);  // 100000 + 200000 would wrap if unclamped
    step(); check("R2", MAXV, 1'b0);
    load(-100000, -20000, 0);
    step(); check("R3", MINV, 1'b0);
  endtask

  task automatic t_quadHead();
    load(50, 11, 300);
    quadMode = 1; chainIn = 0;
    step(); check("R5", clampSum(vC, 1'b0), 1'b0);
    step(); check("R5", clampSum(vC, 1'b1), 1'b1);
    step(); check("R5", clampSum(vC, 1'b0), 1'b0);
    // phase now 1; leave and re-enter
    quadMode = 0;
    step(); check("R4", clampSum(vC, 1'b0), 1'b0);
    quadMode = 1;
    step(); check("R9", clampSum(vC, 1'b0), 1'b0);
    step(); check("R9", clampSum(vC, 1'b1), 1'b1);
  endtask

  task automatic t_chain();
    load(-40, 9, -60);
    quadMode = 0; step();
    quadMode = 1; chainIn = 1;
    cascQual = 1; step(); check("R6", clampSum(vC, 1'b1), 1'b1);
    cascQual = 1; step(); check("R6", clampSum(vC, 1'b1), 1'b1);
    cascQual = 0; step(); check("R6", clampSum(vC, 1'b0), 1'b0);
    cascQual = 0; step(); check("R6", clampSum(vC, 1'b0), 1'b0);
    chainIn = 0; cascQual = 0; quadMode = 0; step();
  endtask

  task automatic t_oe();
    int e;
    quadMode = 0;
    load(777, 3, 0);
    e = clampSum(vC, 1'b0);
    step(); check("R7", e, 1'b0);
    outEn = 0;
    #1 check("R7", 0, 1'b0);
    load(-900, 8, 0);
    e = clampSum(vC, 1'b0);
    step(); check("R7", 0, 1'b0);
    outEn = 1;
    #1 check("R7", e, 1'b0);
    quadMode = 1; outEn = 0;
    step(); check("R7", 0, 1'b0);
    step(); check("R7", 0, 1'b0);
    outEn = 1;
    #1 check("R7", clampSum(vC, 1'b1), 1'b1);
    quadMode = 0;
  endtask

  initial begin
    #(20 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: out=%0d qual=%0b expected out=finished qual=finished", $signed(wbOut), wbQual);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rstN = 1;
    step();
    t_reset();
    t_real();
    t_sat();
    t_quadHead();
    t_chain();
    t_oe();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule